// File: doc/BRIEF.md
# Video Line Descriptor Capture and Stream Checker

This block sits in the pixel clock domain, in front of a packetizer for a camera serial link. It watches up to sixteen virtual channels, each with its own active-high horizontal and vertical sync. When a vertical sync rises, it stores that channel's frame number. When a horizontal sync rises, it latches the data type, the pixel count and the line number from the shared inputs. One cycle later it presents them, with the stored frame number and the channel index, alongside a single-cycle line-start strobe.

The block also checks the pixel-valid input against the streaming rule. Once valid goes high for a line, it must stay high with no gaps for exactly pixel-count / pixels-per-clock cycles. A pixel count that is not a whole multiple of the pixels-per-clock parameter would leave the last data word partly filled, so it is flagged when the line is captured. All error flags are sticky until reset.

Top module: `vline_capture`

## Requirements
- R1: Out of reset, line_start, all descriptor outputs and all four error flags are 0.
- R2: A rising edge of hsync on channel c, seen at a clock edge, makes line_start high for exactly the following cycle. During that cycle line_vc = c, and line_dtype, line_pixcnt and line_num hold the values that dtype_in, pix_count_in and line_in had at that edge.
- R3: A rising edge of vsync on a channel stores frame_in for that channel only. line_frame shows the value stored for the captured channel. If that channel's vsync rises at the same edge as its hsync, the new frame_in is used.
- R4: If hsync rises on more than one channel at the same edge, err_conflict is set and the lowest-numbered channel is captured.
- R5: If the captured pixel count is not a whole multiple of PPC (PPC=4 by default, so the low two bits are not zero), err_align is set in the same cycle that line_start is high.
- R6: After a capture, the line expects pix_count/PPC valid cycles (integer division). If pix_valid falls before that many cycles, err_short is set one cycle later.
- R7: err_long is set by any pix_valid cycle beyond the expected count. It is also set by pix_valid high while no line is armed, including after reset.
- R8: Every error flag stays at 1 until reset. A line with exactly the expected count of gap-free valid cycles sets no length flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | NUM_VC | Per-channel horizontal sync, active high |
| vsync | input | NUM_VC | Per-channel vertical sync, active high |
| dtype_in | input | DT_W | Data type, sampled on an hsync rise |
| pix_count_in | input | CNT_W | Pixels in the line, sampled on an hsync rise |
| line_in | input | LINE_W | Line number, sampled on an hsync rise |
| frame_in | input | FRAME_W | Frame number, sampled on a vsync rise |
| pix_valid | input | 1 | Pixel word valid |
| line_start | output | 1 | One-cycle strobe when a new descriptor is presented |
| line_vc | output | VC_W | Channel index of the captured line |
| line_dtype | output | DT_W | Captured data type |
| line_pixcnt | output | CNT_W | Captured pixel count |
| line_num | output | LINE_W | Captured line number |
| line_frame | output | FRAME_W | Frame number of the captured channel |
| err_conflict | output | 1 | Sticky: hsync rose on several channels at once |
| err_align | output | 1 | Sticky: pixel count not a multiple of PPC |
| err_short | output | 1 | Sticky: valid dropped before the expected count |
| err_long | output | 1 | Sticky: valid beyond the expected count, or with no line armed |

## Verification
The bench goes after several corner cases, each of which a plausible bug would get wrong. When hsync rises on two channels at once, a wrong priority encoder presents the higher channel or misses the conflict flag. When vsync and hsync rise at the same edge, a design without the same-cycle bypass reports the stale frame number. When frames are stored on two channels, a shared frame register leaks one channel's number into the other's line. The length checks cover a line cut one word short, a line overrun by two words, a stray valid with no line armed and a misaligned count with a correct word count. An off-by-one counter shows up as a false flag on the clean lines or a missing flag on the bad ones.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

   typedef enum logic [1:0] {
      CHK_IDLE  = 2'd0,
      CHK_ARMED = 2'd1,
      CHK_RUN   = 2'd2
   } chk_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vlc_edge_bank.sv
module vlc_edge_bank #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise
);

   if (N < 1) begin : g_bad_n
      $error("vlc_edge_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_ch
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= sig[i];
      end
      assign rise[i] = sig[i] & ~prev_q;
   end

endmodule

// File: rtl/vlc_first_pick.sv
module vlc_first_pick #(
   parameter int N     = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic             multi,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |req;
   assign multi = ($countones(req) > 1);

endmodule

// File: rtl/vlc_frame_bank.sv
module vlc_frame_bank #(
   parameter int N     = 16,
   parameter int FW    = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     wr,
   input  logic [FW-1:0]    din,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [FW-1:0]    dout
);

   logic [FW-1:0] store [N];

   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)     store[i] <= '0;
         else if (wr[i]) store[i] <= din;
      end
   end

   // a write to the selected slot at this edge wins over the stored value
   assign dout = wr[rd_idx] ? din : store[rd_idx];

endmodule

// File: rtl/vlc_word_check.sv
module vlc_word_check
   import vlc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic [CW-1:0] words,
   input  logic          valid,
   output logic          err_short,
   output logic          err_long
);

   chk_state_t    state_q;
   logic [CW-1:0] exp_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= CHK_IDLE;
         exp_q     <= '0;
         cnt_q     <= '0;
         err_short <= 1'b0;
         err_long  <= 1'b0;
      end else if (arm) begin
         state_q <= CHK_ARMED;
         exp_q   <= words;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            CHK_IDLE: begin
               if (valid) err_long <= 1'b1;
            end
            CHK_ARMED: begin
               if (valid) begin
                  state_q <= CHK_RUN;
                  if (exp_q == '0) err_long <= 1'b1;
                  else             cnt_q    <= CW'(1);
               end
            end
            CHK_RUN: begin
               if (valid) begin
                  if (cnt_q == exp_q) err_long <= 1'b1;
                  else                cnt_q    <= cnt_q + 1'b1;
               end else begin
                  if (cnt_q < exp_q) err_short <= 1'b1;
                  state_q <= CHK_IDLE;
               end
            end
            default: state_q <= CHK_IDLE;
         endcase
      end
   end

   // R6
   short_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_short) |-> !$past(valid) && $past(valid, 2));

   // R7
   long_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_long) |-> $past(valid));

   // R8
   short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_short |=> err_short);

   // R8
   long_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_long |=> err_long);

endmodule

// File: rtl/vline_capture.sv
module vline_capture
   import vlc_pkg::*;
#(
   parameter int NUM_VC  = 16,
   parameter int DT_W    = 6,
   parameter int CNT_W   = 16,
   parameter int LINE_W  = 16,
   parameter int FRAME_W = 16,
   parameter int PPC     = 4,
   localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int PPC_LG = (PPC > 1) ? $clog2(PPC) : 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VC-1:0]  hsync,
   input  logic [NUM_VC-1:0]  vsync,
   input  logic [DT_W-1:0]    dtype_in,
   input  logic [CNT_W-1:0]   pix_count_in,
   input  logic [LINE_W-1:0]  line_in,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               pix_valid,
   output logic               line_start,
   output logic [VC_W-1:0]    line_vc,
   output logic [DT_W-1:0]    line_dtype,
   output logic [CNT_W-1:0]   line_pixcnt,
   output logic [LINE_W-1:0]  line_num,
   output logic [FRAME_W-1:0] line_frame,
   output logic               err_conflict,
   output logic               err_align,
   output logic               err_short,
   output logic               err_long
);

   if (!is_pow2(PPC)) begin : g_bad_ppc
      $error("vline_capture: PPC must be a power of two");
   end
   if (PPC_LG >= CNT_W) begin : g_bad_cnt
      $error("vline_capture: CNT_W too narrow for PPC");
   end
   if (NUM_VC < 2) begin : g_bad_vc
      $error("vline_capture: NUM_VC must be at least 2");
   end

   logic [NUM_VC-1:0]  hs_rise;
   logic [NUM_VC-1:0]  vs_rise;
   logic               pick_any;
   logic               pick_multi;
   logic [VC_W-1:0]    pick_idx;
   logic [FRAME_W-1:0] frame_sel;
   logic [CNT_W-1:0]   words;
   logic               misalign;

   vlc_edge_bank #(.N(NUM_VC)) u_hs_edge (
      .clk(clk), .rst_n(rst_n), .sig(hsync), .rise(hs_rise));

   vlc_edge_bank #(.N(NUM_VC)) u_vs_edge (
      .clk(clk), .rst_n(rst_n), .sig(vsync), .rise(vs_rise));

   vlc_first_pick #(.N(NUM_VC), .IDX_W(VC_W)) u_pick (
      .req(hs_rise), .any(pick_any), .multi(pick_multi), .idx(pick_idx));

   vlc_frame_bank #(.N(NUM_VC), .FW(FRAME_W), .IDX_W(VC_W)) u_frames (
      .clk(clk), .rst_n(rst_n), .wr(vs_rise), .din(frame_in),
      .rd_idx(pick_idx), .dout(frame_sel));

   if (PPC_LG == 0) begin : g_ppc_one
      assign words    = pix_count_in;
      assign misalign = 1'b0;
   end else begin : g_ppc_multi
      assign words    = pix_count_in >> PPC_LG;
      assign misalign = |pix_count_in[PPC_LG-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_start   <= 1'b0;
         line_vc      <= '0;
         line_dtype   <= '0;
         line_pixcnt  <= '0;
         line_num     <= '0;
         line_frame   <= '0;
         err_conflict <= 1'b0;
         err_align    <= 1'b0;
      end else begin
         line_start <= pick_any;
         if (pick_any) begin
            line_vc     <= pick_idx;
            line_dtype  <= dtype_in;
            line_pixcnt <= pix_count_in;
            line_num    <= line_in;
            line_frame  <= frame_sel;
            if (misalign) err_align <= 1'b1;
         end
         if (pick_multi) err_conflict <= 1'b1;
      end
   end

   vlc_word_check #(.CW(CNT_W)) u_check (
      .clk(clk), .rst_n(rst_n), .arm(pick_any), .words(words),
      .valid(pix_valid), .err_short(err_short), .err_long(err_long));

   // R2
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> $past(|hs_rise));

   // R4
   pick_is_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> hs_rise[pick_idx]);

   // R4
   pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> ((hs_rise & ((NUM_VC'(1) << pick_idx) - NUM_VC'(1))) == '0));

   // R4
   conflict_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hs_rise) > 1) |=> err_conflict);

   // R8
   conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_conflict |=> err_conflict);

   // R5
   align_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_align) |-> line_start);

endmodule

// File: tb/sim_vline_capture.sv
module sim_vline_capture;

   localparam int NV = 16;
   localparam int PPC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NV-1:0] hsync = '0;
   logic [NV-1:0] vsync = '0;
   logic [5:0]    dtype_in = '0;
   logic [15:0]   pix_count_in = '0;
   logic [15:0]   line_in = '0;
   logic [15:0]   frame_in = '0;
   logic          pix_valid = 1'b0;
   logic          line_start;
   logic [3:0]    line_vc;
   logic [5:0]    line_dtype;
   logic [15:0]   line_pixcnt, line_num, line_frame;
   logic          err_conflict, err_align, err_short, err_long;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   vline_capture u0 (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .dtype_in(dtype_in), .pix_count_in(pix_count_in), .line_in(line_in),
      .frame_in(frame_in), .pix_valid(pix_valid), .line_start(line_start),
      .line_vc(line_vc), .line_dtype(line_dtype), .line_pixcnt(line_pixcnt),
      .line_num(line_num), .line_frame(line_frame),
      .err_conflict(err_conflict), .err_align(err_align),
      .err_short(err_short), .err_long(err_long));

   typedef struct packed {
      logic [3:0]  vc;
      logic [15:0] cnt;
      logic [15:0] ln;
      logic [15:0] fr;
      logic [5:0]  dt;
      logic [7:0]  nw;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t TBL [NVEC] = '{
      '{vc: 4'd0,  cnt: 16'd16, ln: 16'd1,    fr: 16'h0011, dt: 6'h2a, nw: 8'd4},
      '{vc: 4'd15, cnt: 16'd64, ln: 16'hffff, fr: 16'hbeef, dt: 6'h24, nw: 8'd16},
      '{vc: 4'd7,  cnt: 16'd8,  ln: 16'd300,  fr: 16'h0707, dt: 6'h1e, nw: 8'd1},
      '{vc: 4'd3,  cnt: 16'd12, ln: 16'd42,   fr: 16'h3333, dt: 6'h2b, nw: 8'd5},
      '{vc: 4'd9,  cnt: 16'd10, ln: 16'd9,    fr: 16'h9999, dt: 6'h3f, nw: 8'd2},
      '{vc: 4'd5,  cnt: 16'd4,  ln: 16'd0,    fr: 16'h5555, dt: 6'h00, nw: 8'd1}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; hsync = '0; vsync = '0; pix_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v);
      int words;
      do_reset();
      words = int'(v.cnt) / PPC;
      vsync[v.vc] = 1'b1; frame_in = v.fr;
      @(negedge clk);
      vsync = '0; frame_in = 16'hdead;
      @(negedge clk);
      hsync[v.vc] = 1'b1; dtype_in = v.dt; pix_count_in = v.cnt; line_in = v.ln;
      @(negedge clk);
      chk("R2", "line_start", 32'(line_start), 32'd1);
      chk("R2", "line_vc", 32'(line_vc), 32'(v.vc));
      chk("R2", "line_dtype", 32'(line_dtype), 32'(v.dt));
      chk("R2", "line_pixcnt", 32'(line_pixcnt), 32'(v.cnt));
      chk("R2", "line_num", 32'(line_num), 32'(v.ln));
      chk("R3", "line_frame", 32'(line_frame), 32'(v.fr));
      chk("R5", "err_align", 32'(err_align), 32'((v.cnt % PPC) != 0));
      hsync = '0; dtype_in = '1; pix_count_in = '1; line_in = '1;
      @(negedge clk);
      chk("R2", "line_start low after one cycle", 32'(line_start), 32'd0);
      for (int i = 0; i < int'(v.nw); i++) begin
         pix_valid = 1'b1;
         @(negedge clk);
      end
      pix_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6", "err_short", 32'(err_short), 32'(int'(v.nw) < words));
      chk("R7", "err_long", 32'(err_long), 32'(int'(v.nw) > words));
      chk("R8", "err_conflict clean", 32'(err_conflict), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1", "line_start", 32'(line_start), 32'd0);
      chk("R1", "descriptor", 32'(line_vc) | 32'(line_pixcnt) | 32'(line_frame), 32'd0);
      chk("R1", "errors", {28'd0, err_conflict, err_align, err_short, err_long}, 32'd0);

      for (int k = 0; k < NVEC; k++) run_vec(TBL[k]);

      // R4 simultaneous rise: lowest channel wins, conflict flagged and kept
      do_reset();
      hsync[6] = 1'b1; hsync[2] = 1'b1; pix_count_in = 16'd8; line_in = 16'd77;
      @(negedge clk);
      chk("R4", "line_vc lowest", 32'(line_vc), 32'd2);
      chk("R4", "err_conflict", 32'(err_conflict), 32'd1);
      hsync = '0;
      repeat (3) @(negedge clk);
      chk("R8", "err_conflict sticky", 32'(err_conflict), 32'd1);

      // R3 same-edge vsync and hsync uses the new frame
      do_reset();
      vsync[4] = 1'b1; hsync[4] = 1'b1; frame_in = 16'h4242; pix_count_in = 16'd4;
      @(negedge clk);
      chk("R3", "bypass frame", 32'(line_frame), 32'h4242);
      vsync = '0; hsync = '0;

      // R3 per-channel frame storage
      do_reset();
      vsync[1] = 1'b1; frame_in = 16'haaaa;
      @(negedge clk);
      vsync = '0;
      @(negedge clk);
      vsync[2] = 1'b1; frame_in = 16'hbbbb;
      @(negedge clk);
      vsync = '0; frame_in = 16'h0;
      @(negedge clk);
      hsync[1] = 1'b1;
      @(negedge clk);
      chk("R3", "channel 1 frame", 32'(line_frame), 32'haaaa);
      hsync = '0;
      @(negedge clk);
      hsync[2] = 1'b1;
      @(negedge clk);
      chk("R3", "channel 2 frame", 32'(line_frame), 32'hbbbb);
      hsync = '0;

      // R7 stray valid with no line armed
      do_reset();
      pix_valid = 1'b1;
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
      chk("R7", "stray valid", 32'(err_long), 32'd1);
      chk("R6", "no short on stray", 32'(err_short), 32'd0);
      repeat (3) @(negedge clk);
      chk("R8", "err_long sticky", 32'(err_long), 32'd1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule